// File: doc/BRIEF.md
# Speculative Access Tracking Tags

This block is the tag side of a direct-indexed primary data cache model. Alongside each line's address tag it keeps four state bits: valid, dirty, speculatively-read and speculatively-written. Loads and stores that run inside a speculative region mark the lines they touch. Incoming external coherence requests are compared against those marks, and a potential ordering violation is flagged. Data storage, the coherence engine and register checkpointing live elsewhere.

Two bulk operations act on every line in a single cycle. Commit drops all speculative marks. Abort drops the valid bit of every line that holds speculative writes. A speculative store to a dirty line that is not yet marked first asks for a clean writeback. It is applied only after the cleaning is reported back. A fill that would displace a speculatively marked line is refused, and a forced commit is requested in its place.

A line address is split in two: the low `IDX_W` bits select the line and the remaining upper bits form the tag. The access opcode `acc_op` is coded as follows: 0 = load, 1 = store, 2 = fill (install the line after a miss), 3 = clean-done (the writeback of this line has completed).

Top module: `spec_tag_array`

## Requirements
- R1: Under reset every line becomes invalid and every output is low. After reset, a lookup of any address reports a miss.
- R2: A fill (op 2) installs the addressed tag as valid, clean and unmarked. A later lookup of the same address hits. A lookup with a different tag at the same index misses.
- R3: A speculative load hit sets the line's speculatively-read mark. After that, an external write snoop to the line raises `violation`, and an external read snoop does not.
- R4: A non-speculative load or store leaves both speculative marks unchanged. A non-speculative store hit makes the line dirty.
- R5: A speculative store hit on a line that is clean or already speculatively written sets the speculatively-written mark and the dirty bit, with `rsp_clean_req` low. After that, an external snoop of either kind to the line raises `violation`.
- R6: A speculative store hit on a dirty line that is not speculatively written raises `rsp_clean_req` and changes nothing. A clean-done (op 3) on the line clears its dirty bit, and the retried store is then applied.
- R7: A fill whose index holds a valid line with either speculative mark set raises `rsp_commit_req` and keeps the old line. A fill over an unmarked line replaces it.
- R8: `flash_clear` zeroes every speculatively-read and speculatively-written mark in one cycle and leaves valid and dirty unchanged.
- R9: `flash_inval` makes invalid, in one cycle, every line whose speculatively-written mark is set. Other lines and the read marks are unaffected.
- R10: When `flash_clear` and `flash_inval` are asserted in the same cycle, the invalidation uses the marks held before the clear. Written lines become invalid and all marks end up cleared.
- R11: `rsp_valid` is high exactly one cycle after a valid access, and the other response bits are low when it is low. `violation` appears one cycle after the snoop and is judged on the marks held before that edge.
- R12: A snoop whose address misses (tag mismatch or invalid line) never raises `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request present |
| acc_op | input | 2 | 0 load, 1 store, 2 fill, 3 clean-done |
| acc_spec | input | 1 | Access belongs to a speculative region |
| acc_addr | input | ADDR_W | Line address: index in low bits, tag above |
| snp_valid | input | 1 | External coherence request present |
| snp_write | input | 1 | External request asks for write permission |
| snp_addr | input | ADDR_W | Line address of the external request |
| flash_clear | input | 1 | Commit: clear all speculative marks |
| flash_inval | input | 1 | Abort: invalidate all speculatively written lines |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_hit | output | 1 | Access matched a valid line |
| rsp_clean_req | output | 1 | Clean writeback needed before the speculative store |
| rsp_commit_req | output | 1 | Fill refused; a forced commit is needed |
| violation | output | 1 | Previous cycle's snoop conflicts with speculative marks |

## Verification
A wrong mark shows up only when a later request touches that line. A lost read mark hides a write-snoop violation. A stale written mark raises a violation on a harmless read snoop, or lets an abort destroy a line it should not touch. Each of these appears one cycle after the probing snoop, fill or lookup. For this reason every marking step is followed at once by a probe, and every bulk operation is followed by probes of lines both with and without marks.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FILL  = 2'd2,
    OP_CLEAN = 2'd3
  } op_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic sr;
    logic sw;
  } mark_t;
endpackage

// File: rtl/spec_tag_cell.sv
module spec_tag_cell
  import spec_tag_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  mark_t            wr_mark,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             flash_clr,
  input  logic             flash_inv,
  output mark_t            mark,
  output logic [TAG_W-1:0] tag
);
  mark_t d;

  // Bulk operations look at the bits held before this edge.
  always_comb begin
    d = wr_en ? wr_mark : mark;
    if (flash_inv && mark.sw) d.valid = 1'b0;
    if (flash_clr) begin
      d.sr = 1'b0;
      d.sw = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mark <= '0;
    else     mark <= d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag <= wr_tag;
  end
endmodule

// File: rtl/spec_tag_decide.sv
module spec_tag_decide
  import spec_tag_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  op_e              op,
  input  logic             spec,
  input  logic [TAG_W-1:0] req_tag,
  input  mark_t            cur,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             hit,
  output logic             upd,
  output mark_t            nxt,
  output logic             clean_req,
  output logic             commit_req
);
  always_comb begin
    hit        = cur.valid && (cur_tag == req_tag);
    upd        = 1'b0;
    nxt        = cur;
    clean_req  = 1'b0;
    commit_req = 1'b0;
    case (op)
      OP_LOAD: begin
        if (hit && spec) begin
          upd    = 1'b1;
          nxt.sr = 1'b1;
        end
      end
      OP_STORE: begin
        if (hit) begin
          if (spec && cur.dirty && !cur.sw) begin
            clean_req = 1'b1;
          end else begin
            upd       = 1'b1;
            nxt.dirty = 1'b1;
            if (spec) nxt.sw = 1'b1;
          end
        end
      end
      OP_FILL: begin
        if (!hit) begin
          if (cur.valid && (cur.sr || cur.sw)) begin
            commit_req = 1'b1;
          end else begin
            upd = 1'b1;
            nxt = '{valid: 1'b1, dirty: 1'b0, sr: 1'b0, sw: 1'b0};
          end
        end
      end
      OP_CLEAN: begin
        if (hit) begin
          upd       = 1'b1;
          nxt.dirty = 1'b0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/spec_tag_array.sv
module spec_tag_array
  import spec_tag_pkg::*;
#(
  parameter int LINES = 1024,
  parameter int TAG_W = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op,
  input  logic              acc_spec,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              flash_clear,
  input  logic              flash_inval,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_clean_req,
  output logic              rsp_commit_req,
  output logic              violation
);
  mark_t            marks [LINES];
  logic [TAG_W-1:0] tags  [LINES];

  logic [IDX_W-1:0] a_idx, s_idx;
  logic [TAG_W-1:0] a_tag, s_tag;
  assign a_idx = acc_addr[IDX_W-1:0];
  assign a_tag = acc_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  mark_t a_cur, a_nxt, s_cur;
  logic  a_hit, a_upd, a_clean, a_commit;
  assign a_cur = marks[a_idx];
  assign s_cur = marks[s_idx];

  spec_tag_decide #(.TAG_W(TAG_W)) u_decide (
    .op        (op_e'(acc_op)),
    .spec      (acc_spec),
    .req_tag   (a_tag),
    .cur       (a_cur),
    .cur_tag   (tags[a_idx]),
    .hit       (a_hit),
    .upd       (a_upd),
    .nxt       (a_nxt),
    .clean_req (a_clean),
    .commit_req(a_commit)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    spec_tag_cell #(.TAG_W(TAG_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (acc_valid && a_upd && (a_idx == IDX_W'(i))),
      .wr_mark  (a_nxt),
      .wr_tag   (a_tag),
      .flash_clr(flash_clear),
      .flash_inv(flash_inval),
      .mark     (marks[i]),
      .tag      (tags[i])
    );
  end

  logic s_conflict;
  assign s_conflict = s_cur.valid && (tags[s_idx] == s_tag) &&
                      (s_cur.sw || (snp_write && s_cur.sr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_clean_req  <= 1'b0;
      rsp_commit_req <= 1'b0;
      violation      <= 1'b0;
    end else begin
      rsp_valid      <= acc_valid;
      rsp_hit        <= acc_valid && a_hit;
      rsp_clean_req  <= acc_valid && a_clean;
      rsp_commit_req <= acc_valid && a_commit;
      violation      <= snp_valid && s_conflict;
    end
  end
endmodule

// File: rtl/spec_tag_array_chk.sv
module spec_tag_array_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic [1:0] acc_op,
  input logic       acc_spec,
  input logic       snp_valid,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_clean_req,
  input logic       rsp_commit_req,
  input logic       violation
);
  a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);
  a_r11_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid && !rsp_hit && !rsp_clean_req && !rsp_commit_req);
  a_r12_viol_needs_snoop: assert property (@(posedge clk) disable iff (rst)
    violation |-> $past(snp_valid));
  a_r6_clean_on_spec_store: assert property (@(posedge clk) disable iff (rst)
    rsp_clean_req |-> rsp_hit && $past(acc_op) == 2'd1 && $past(acc_spec));
  a_r7_commit_on_fill_miss: assert property (@(posedge clk) disable iff (rst)
    rsp_commit_req |-> !rsp_hit && !rsp_clean_req && $past(acc_op) == 2'd2);
endmodule

bind spec_tag_array spec_tag_array_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_op        (acc_op),
  .acc_spec      (acc_spec),
  .snp_valid     (snp_valid),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_clean_req (rsp_clean_req),
  .rsp_commit_req(rsp_commit_req),
  .violation     (violation)
);

// File: tb/spec_tag_array_tb.sv
`timescale 1ns/1ps
module spec_tag_array_tb;
  localparam int LINES = 1024;
  localparam int TAG_W = 8;
  localparam int AW    = 18;

  // access kinds: 0 none, 1 load, 2 store, 3 fill, 4 clean-done
  localparam logic [2:0] KN = 3'd0, KL = 3'd1, KS = 3'd2, KF = 3'd3, KC = 3'd4;
  // snoop kinds: 0 none, 1 read, 2 write
  localparam logic [1:0] SN = 2'd0, SR = 2'd1, SW = 2'd2;

  localparam logic [AW-1:0] Z  = '0;
  localparam logic [AW-1:0] A0 = {8'h11, 10'd5};
  localparam logic [AW-1:0] A1 = {8'h22, 10'd5};
  localparam logic [AW-1:0] B0 = {8'h33, 10'd9};
  localparam logic [AW-1:0] C0 = {8'h44, 10'd12};
  localparam logic [AW-1:0] D0 = {8'h55, 10'd12};
  localparam logic [AW-1:0] E0 = {8'h66, 10'd100};

  typedef struct packed {
    logic [3:0]    rq;
    logic [2:0]    k;
    logic          sp;
    logic [AW-1:0] a;
    logic [1:0]    sk;
    logic [AW-1:0] sa;
    logic [1:0]    fl;   // {clear, inval}
    logic [4:0]    ex;   // {valid, hit, clean, commit, viol}
  } vec_t;

  localparam int NV = 47;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  KL, 1'b0, A0, SN, Z,  2'b00, 5'b10000}, // R1 miss after reset
    '{4'd2,  KF, 1'b0, A0, SN, Z,  2'b00, 5'b10000}, // R2 install
    '{4'd2,  KL, 1'b0, A0, SN, Z,  2'b00, 5'b11000}, // R2 hit
    '{4'd2,  KL, 1'b0, A1, SN, Z,  2'b00, 5'b10000}, // R2 other tag misses
    '{4'd4,  KN, 1'b0, Z,  SW, A0, 2'b00, 5'b00000}, // R4 no read mark
    '{4'd3,  KL, 1'b1, A0, SN, Z,  2'b00, 5'b11000}, // R3 spec load
    '{4'd3,  KN, 1'b0, Z,  SR, A0, 2'b00, 5'b00000}, // R3 read snoop ok
    '{4'd3,  KN, 1'b0, Z,  SW, A0, 2'b00, 5'b00001}, // R3 write snoop flags
    '{4'd11, KN, 1'b0, Z,  SN, Z,  2'b00, 5'b00000}, // R11 one-cycle flag
    '{4'd7,  KF, 1'b0, A1, SN, Z,  2'b00, 5'b10010}, // R7 refused fill
    '{4'd7,  KL, 1'b0, A0, SN, Z,  2'b00, 5'b11000}, // R7 old line kept
    '{4'd2,  KF, 1'b0, B0, SN, Z,  2'b00, 5'b10000}, // R2
    '{4'd4,  KS, 1'b0, B0, SN, Z,  2'b00, 5'b11000}, // R4 dirty
    '{4'd4,  KN, 1'b0, Z,  SR, B0, 2'b00, 5'b00000}, // R4 no write mark
    '{4'd6,  KS, 1'b1, B0, SN, Z,  2'b00, 5'b11100}, // R6 clean needed
    '{4'd6,  KN, 1'b0, Z,  SR, B0, 2'b00, 5'b00000}, // R6 store not applied
    '{4'd6,  KC, 1'b0, B0, SN, Z,  2'b00, 5'b11000}, // R6 clean done
    '{4'd6,  KS, 1'b1, B0, SN, Z,  2'b00, 5'b11000}, // R6 retry applied
    '{4'd5,  KN, 1'b0, Z,  SR, B0, 2'b00, 5'b00001}, // R5 any snoop flags
    '{4'd5,  KS, 1'b1, B0, SN, Z,  2'b00, 5'b11000}, // R5 already written
    '{4'd2,  KF, 1'b0, C0, SN, Z,  2'b00, 5'b10000}, // R2
    '{4'd5,  KS, 1'b1, C0, SN, Z,  2'b00, 5'b11000}, // R5 clean line
    '{4'd5,  KN, 1'b0, Z,  SW, C0, 2'b00, 5'b00001}, // R5
    '{4'd12, KN, 1'b0, Z,  SW, D0, 2'b00, 5'b00000}, // R12 tag mismatch
    '{4'd12, KN, 1'b0, Z,  SW, E0, 2'b00, 5'b00000}, // R12 invalid line
    '{4'd8,  KN, 1'b0, Z,  SN, Z,  2'b10, 5'b00000}, // R8 flash clear
    '{4'd8,  KN, 1'b0, Z,  SW, A0, 2'b00, 5'b00000}, // R8 read mark gone
    '{4'd8,  KN, 1'b0, Z,  SR, B0, 2'b00, 5'b00000}, // R8 write mark gone
    '{4'd8,  KL, 1'b0, B0, SN, Z,  2'b00, 5'b11000}, // R8 still valid
    '{4'd7,  KF, 1'b0, A1, SN, Z,  2'b00, 5'b10000}, // R7 replace
    '{4'd7,  KL, 1'b0, A0, SN, Z,  2'b00, 5'b10000}, // R7 old gone
    '{4'd7,  KL, 1'b0, A1, SN, Z,  2'b00, 5'b11000}, // R7 new present
    '{4'd9,  KC, 1'b0, C0, SN, Z,  2'b00, 5'b11000}, // R9 setup
    '{4'd9,  KS, 1'b1, C0, SN, Z,  2'b00, 5'b11000}, // R9 mark written
    '{4'd9,  KL, 1'b1, A1, SN, Z,  2'b00, 5'b11000}, // R9 mark read
    '{4'd9,  KN, 1'b0, Z,  SN, Z,  2'b01, 5'b00000}, // R9 flash inval
    '{4'd9,  KL, 1'b0, C0, SN, Z,  2'b00, 5'b10000}, // R9 written line gone
    '{4'd9,  KL, 1'b0, A1, SN, Z,  2'b00, 5'b11000}, // R9 read line kept
    '{4'd9,  KN, 1'b0, Z,  SW, A1, 2'b00, 5'b00001}, // R9 read mark kept
    '{4'd10, KC, 1'b0, B0, SN, Z,  2'b00, 5'b11000}, // R10 setup
    '{4'd10, KS, 1'b1, B0, SN, Z,  2'b00, 5'b11000}, // R10 mark written
    '{4'd10, KN, 1'b0, Z,  SN, Z,  2'b11, 5'b00000}, // R10 both flashes
    '{4'd10, KL, 1'b0, B0, SN, Z,  2'b00, 5'b10000}, // R10 invalidated
    '{4'd10, KN, 1'b0, Z,  SW, A1, 2'b00, 5'b00000}, // R10 marks cleared
    '{4'd10, KL, 1'b0, A1, SN, Z,  2'b00, 5'b11000}, // R10 unwritten kept
    '{4'd11, KL, 1'b1, A1, SW, A1, 2'b00, 5'b11000}, // R11 snoop sees old
    '{4'd11, KN, 1'b0, Z,  SW, A1, 2'b00, 5'b00001}  // R11 mark now seen
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0, acc_spec = 1'b0;
  logic [1:0]    acc_op = 2'd0;
  logic [AW-1:0] acc_addr = '0, snp_addr = '0;
  logic          snp_valid = 1'b0, snp_write = 1'b0;
  logic          flash_clear = 1'b0, flash_inval = 1'b0;
  logic          rsp_valid, rsp_hit, rsp_clean_req, rsp_commit_req, violation;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  spec_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_spec(acc_spec), .acc_addr(acc_addr),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .flash_clear(flash_clear), .flash_inval(flash_inval),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_clean_req(rsp_clean_req),
    .rsp_commit_req(rsp_commit_req), .violation(violation)
  );

  function automatic logic [4:0] outs();
    return {rsp_valid, rsp_hit, rsp_clean_req, rsp_commit_req, violation};
  endfunction

  task automatic check(input int rq, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d outs got %b expected %b", rq, got, exp);
    end
  endtask

  // Drive at a falling edge; the next falling edge follows the capturing rising edge.
  task automatic apply(input vec_t v);
    acc_valid   = (v.k != KN);
    acc_op      = (v.k == KS) ? 2'd1 : (v.k == KF) ? 2'd2 : (v.k == KC) ? 2'd3 : 2'd0;
    acc_spec    = v.sp;
    acc_addr    = v.a;
    snp_valid   = (v.sk != SN);
    snp_write   = (v.sk == SW);
    snp_addr    = v.sa;
    flash_clear = v.fl[1];
    flash_inval = v.fl[0];
    @(negedge clk);
    check(int'(v.rq), outs(), v.ex);
  endtask

  task automatic idle();
    acc_valid = 1'b0; snp_valid = 1'b0; flash_clear = 1'b0; flash_inval = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, outs(), 5'b00000);               // R1 outputs low in reset
    rst = 1'b0;
    @(negedge clk);
    check(1, outs(), 5'b00000);               // R1 idle after reset
    for (int i = 0; i < NV; i++) apply(TBL[i]);
    idle();
    @(negedge clk);
    check(11, outs(), 5'b00000);              // R11 idle gives nothing
    rst = 1'b1;                               // R1 reset mid-run
    repeat (2) @(negedge clk);
    check(1, outs(), 5'b00000);
    rst = 1'b0;
    apply('{4'd1, KL, 1'b0, A1, SN, Z,  2'b00, 5'b10000}); // R1 line cleared
    apply('{4'd1, KF, 1'b0, A1, SN, Z,  2'b00, 5'b10000}); // R1 fill not refused
    apply('{4'd3, KL, 1'b1, A1, SN, Z,  2'b00, 5'b11000}); // R3 mark again
    apply('{4'd3, KN, 1'b0, Z,  SW, A1, 2'b00, 5'b00001}); // R3
    idle();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule